// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the serial clock of an I2C master. A prescaler divides the functional clock down to an internal tick. Two phase counters then hold SCL low and high for programmed numbers of ticks. Fixed offsets are added in hardware: 7 ticks on the low phase and 5 on the high phase. The block drives a level request for SCL and two single-cycle strobes. One strobe marks where the bus engine should drive data. The other marks where it should sample.

Each of the two timing registers is 16 bits wide and holds two counts. The lower byte is used for standard and fast timing. The upper byte is used for the high-speed portion of a transfer, and high-speed counts are counted in functional-clock cycles with no prescaling. Every transfer that starts from idle runs at fast timing first. The bus engine raises a phase-select input once the master code has been sent, and the generator changes to the high-speed values at its next phase boundary. The timing values can only be loaded while the block is disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, SCL is requested high (`scl_req`=1) and both strobes are low. This stays true while `enable` is high and `clk_req` is low.
- R2: In fast timing, the prescaler divisor is `psc_val`+1. Each tick therefore lasts `psc_val`+1 clock cycles.
- R3: In fast timing, the low phase lasts (`low_cfg`[7:0]+7) ticks and the high phase lasts (`high_cfg`[7:0]+5) ticks.
- R4: `scl_req` goes low one cycle after `clk_req` is sampled high in idle. `drive_stb` is high only in the first cycle of every low phase.
- R5: `sample_stb` is high for exactly one cycle in each high phase. That cycle is at index floor(Nh/2)·D within the phase, where Nh is the length of the high phase in ticks and D is the tick length in cycles. `sample_stb` never coincides with `drive_stb`.
- R6: In high-speed timing, the low phase lasts (`low_cfg`[15:8]+7) clock cycles and the high phase lasts (`high_cfg`[15:8]+5) clock cycles. The prescaler is not applied.
- R7: The `hs_sel` input is taken only at a phase boundary, and a change of it never alters a phase that is already running. The first low phase after idle always uses fast timing, whatever the value of `hs_sel`.
- R8: `cfg_we` loads `psc_val`, `low_cfg` and `high_cfg` only while `enable` is low. A write while `enable` is high is ignored, and the phase durations that follow are unchanged.
- R9: If `clk_req` is low at the end of a high phase, the generator goes idle with SCL high. If `enable` is low, the generator is idle one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; low forces idle and opens the timing registers |
| cfg_we | input | 1 | Timing register write strobe |
| psc_val | input | PW | Prescaler value; tick = psc_val+1 cycles |
| low_cfg | input | 2*CW | Low counts: [CW-1:0] fast, [2CW-1:CW] high-speed |
| high_cfg | input | 2*CW | High counts: [CW-1:0] fast, [2CW-1:CW] high-speed |
| clk_req | input | 1 | Bus engine asks for SCL cycles |
| hs_sel | input | 1 | Use high-speed counts from the next phase boundary |
| scl_req | output | 1 | Requested SCL level (1 = released high) |
| drive_stb | output | 1 | One cycle at the start of each low phase |
| sample_stb | output | 1 | One cycle at the middle of each high phase |

## Verification
The bench uses the default parameters: 8-bit count fields and an 8-bit prescaler. The full set of 2*CW register layouts is therefore exercised. The prescaler values used are small (0, 1 and 2), which keeps each phase to a few dozen cycles. With these values the bench can cover the zero-count case, where only the offsets apply, and a prescaled fast phase followed by an unprescaled high-speed phase in the same run. It also covers a change back to fast timing part-way through a run, and an idle period long enough to show that no further strobes appear.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_cfg_regs.sv
// Timing registers: loaded only while disabled; field chosen by speed mode.
module scl_cfg_regs #(
    parameter int CW = 8,
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cfg_we,
    input  logic [PW-1:0]   psc_in,
    input  logic [2*CW-1:0] low_in,
    input  logic [2*CW-1:0] high_in,
    input  logic            hs,
    output logic [PW-1:0]   psc_o,
    output logic [CW-1:0]   low_o,
    output logic [CW-1:0]   high_o
);
    typedef struct packed {
        logic [PW-1:0]   psc;
        logic [2*CW-1:0] low;
        logic [2*CW-1:0] high;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we && !enable) begin
            r_d.psc  = psc_in;
            r_d.low  = low_in;
            r_d.high = high_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign psc_o  = r_q.psc;
    assign low_o  = hs ? r_q.low[2*CW-1:CW]  : r_q.low[CW-1:0];
    assign high_o = hs ? r_q.high[2*CW-1:CW] : r_q.high[CW-1:0];

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (r_q == $past(r_q)));
endmodule

// File: rtl/scl_prescaler.sv
// Tick generator: divides by div+1, or passes every cycle when bypassed.
module scl_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          bypass,
    input  logic [PW-1:0] div,
    output logic          tick,
    output logic          at_zero
);
    logic [PW-1:0] pcnt_d, pcnt_q;

    always_comb begin
        pcnt_d = pcnt_q + 1'b1;
        if (restart || bypass || pcnt_q == div)
            pcnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    assign tick    = bypass || (pcnt_q == div);
    assign at_zero = (pcnt_q == '0);

    p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || bypass) |=> at_zero);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int CW       = 8,
    parameter int PW       = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cfg_we,
    input  logic [PW-1:0]   psc_val,
    input  logic [2*CW-1:0] low_cfg,
    input  logic [2*CW-1:0] high_cfg,
    input  logic            clk_req,
    input  logic            hs_sel,
    output logic            scl_req,
    output logic            drive_stb,
    output logic            sample_stb
);
    import scl_timer_pkg::*;

    localparam int NW = CW + 1;

    typedef struct packed {
        phase_e        phase;
        logic [NW-1:0] cnt;
        logic          hs;
    } st_t;

    st_t s_d, s_q;

    logic [PW-1:0] psc_w;
    logic [CW-1:0] low_w, high_w;
    logic          tick, pre_zero;
    logic [NW-1:0] lo_lim, hi_lim, mid;

    scl_cfg_regs #(.CW(CW), .PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .psc_in(psc_val), .low_in(low_cfg), .high_in(high_cfg),
        .hs(s_q.hs), .psc_o(psc_w), .low_o(low_w), .high_o(high_w)
    );

    scl_prescaler #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(s_q.phase == PH_IDLE),
        .bypass(s_q.hs), .div(psc_w), .tick(tick), .at_zero(pre_zero)
    );

    assign lo_lim = NW'(low_w)  + NW'(LOW_OFS);
    assign hi_lim = NW'(high_w) + NW'(HIGH_OFS);
    assign mid    = hi_lim >> 1;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            s_d.hs    = 1'b0;
        end else begin
            case (s_q.phase)
                PH_IDLE: begin
                    if (clk_req) begin
                        s_d.phase = PH_LOW;
                        s_d.cnt   = '0;
                        s_d.hs    = 1'b0;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (s_q.cnt == lo_lim - 1'b1) begin
                            s_d.phase = PH_HIGH;
                            s_d.cnt   = '0;
                            s_d.hs    = hs_sel;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (s_q.cnt == hi_lim - 1'b1) begin
                            s_d.cnt = '0;
                            if (clk_req) begin
                                s_d.phase = PH_LOW;
                                s_d.hs    = hs_sel;
                            end else begin
                                s_d.phase = PH_IDLE;
                                s_d.hs    = 1'b0;
                            end
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.hs    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.hs    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_req    = (s_q.phase != PH_LOW);
    assign drive_stb  = (s_q.phase == PH_LOW)  && (s_q.cnt == '0) && pre_zero;
    assign sample_stb = (s_q.phase == PH_HIGH) && (s_q.cnt == mid) && pre_zero;

    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_req && !drive_stb && !sample_stb));
    p_fall_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_req) |-> drive_stb);
    p_sample_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_req && !drive_stb));
    p_start_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |=> !s_q.hs);
endmodule

// File: tb/i2c_scl_timer_tb.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb;
    localparam int CW   = 8;
    localparam int PW   = 8;
    localparam int MAXC = 2000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            cfg_we = 1'b0;
    logic [PW-1:0]   psc_val = '0;
    logic [2*CW-1:0] low_cfg = '0;
    logic [2*CW-1:0] high_cfg = '0;
    logic            clk_req = 1'b0;
    logic            hs_sel = 1'b0;
    logic            scl_req, drive_stb, sample_stb;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    i2c_scl_timer #(.CW(CW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .psc_val(psc_val), .low_cfg(low_cfg), .high_cfg(high_cfg),
        .clk_req(clk_req), .hs_sel(hs_sel), .scl_req(scl_req),
        .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input int p, input int lo, input int hi);
        @(negedge clk);
        psc_val = PW'(p); low_cfg = 16'(lo); high_cfg = 16'(hi); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic quiesce();
        @(negedge clk);
        enable = 1'b0; clk_req = 1'b0; hs_sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // At a negedge in the first cycle of a low phase; returns at the next one.
    task automatic measure(output int lo, output int hi, output int sp);
        lo = 0; hi = 0; sp = -1;
        while (scl_req == 1'b0 && lo < MAXC) begin lo++; @(negedge clk); end
        while (scl_req == 1'b1 && hi < MAXC) begin
            if (sample_stb) sp = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic start_run();
        enable = 1'b1; clk_req = 1'b1;
        @(negedge clk);
        chk("R4 scl low one cycle after request", scl_req, 0);
        chk("R4 drive strobe on first low cycle", drive_stb, 1);
    endtask

    task automatic t_reset();
        chk("R1 reset scl high", scl_req, 1);
        chk("R1 reset no drive strobe", drive_stb, 0);
        chk("R1 reset no sample strobe", sample_stb, 0);
        enable = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!scl_req || drive_stb || sample_stb) seen++;
            end
            chk("R1 enabled without request stays idle", seen, 0);
        end
        quiesce();
    endtask

    task automatic t_fast(input int p, input int lo, input int hi);
        int a, b, s, d, nh;
        d = p + 1; nh = hi + 5;
        load_cfg(p, lo, hi);
        start_run();
        measure(a, b, s);
        chk("R2 R3 fast low duration", a, (lo + 7) * d);
        chk("R2 R3 fast high duration", b, nh * d);
        chk("R5 sample position", s, (nh / 2) * d);
        chk("R4 drive strobe at next low", drive_stb, 1);
        measure(a, b, s);
        chk("R3 second period low", a, (lo + 7) * d);
        quiesce();
    endtask

    task automatic t_hs();
        int a, b, s;
        load_cfg(2, 16'h0203, 16'h0104);
        hs_sel = 1'b1;
        start_run();
        measure(a, b, s);
        chk("R7 first low stays fast", a, 30);
        chk("R6 high in hs counts", b, 6);
        chk("R6 hs sample position", s, 3);
        measure(a, b, s);
        chk("R6 hs low duration", a, 9);
        chk("R6 hs high duration", b, 6);
        hs_sel = 1'b0;
        measure(a, b, s);
        chk("R7 running low kept hs timing", a, 9);
        chk("R7 switch back at boundary high", b, 27);
        chk("R7 fast sample after switch", s, 12);
        quiesce();
    endtask

    task automatic t_cfg_locked();
        int a, b, s;
        load_cfg(2, 3, 4);
        start_run();
        psc_val = '0; low_cfg = '0; high_cfg = '0; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        measure(a, b, s);
        measure(a, b, s);
        chk("R8 write while enabled ignored low", a, 30);
        chk("R8 write while enabled ignored high", b, 27);
        quiesce();
    endtask

    task automatic t_stop();
        int a, b, s;
        load_cfg(2, 3, 4);
        start_run();
        clk_req = 1'b0;
        measure(a, b, s);
        chk("R9 last low completes", a, 30);
        chk("R9 idle high after last phase", b, MAXC);
        chk("R9 single sample in last high", s, 12);
        quiesce();
    endtask

    task automatic t_disable();
        start_run();
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 disable forces scl high", scl_req, 1);
        chk("R9 disable no drive strobe", drive_stb, 0);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast(2, 3, 4);
        t_fast(0, 0, 0);
        t_fast(1, 20, 3);
        t_hs();
        t_cfg_locked();
        t_stop();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule